// File: doc/BRIEF.md
# Color Palette Register Port

This block is the host-facing register port of a color lookup unit. A host writes and reads through four byte-wide registers, chosen by a 2-bit select. One register holds a shared entry pointer. The others reach a 256-entry main color table, a 4-entry overlay color table, and four control bytes. Colors are moved as red, green and blue bytes in sequence. A sub-counter steps through the three components. After the third component the entry is committed and the pointer moves on, so a whole table can be streamed after a single pointer load.

The display side reads colors through a separate lookup port. A 9-bit index selects either a main entry or an overlay entry, and the 24-bit color comes back one cycle later. The control byte that holds the command bits is decoded into two overlay plane enables and a pair of blink on/off periods, counted in frames.

Top module: `cpal_regport`

## Requirements
- R1: After reset the entry pointer, component sub-index, all four control bytes and the read data output are 0, so the overlay enables read 0 and the blink periods are 16 on / 48 off.
- R2: A write to select 0 loads the pointer with the data byte and returns the sub-index to red; a read of select 0 returns the pointer.
- R3: Writes to select 1 store red, green, then blue. The third write commits the triple to main entry [pointer] and advances the pointer by one, wrapping from 255 to 0.
- R4: Reads of select 1 return red, green, then blue of main entry [pointer], with the same advance and wrap. Read data appears on the output one cycle after the strobe and holds until the next read.
- R5: While the pointer is below 4, select 3 writes and reads the overlay entry [pointer] in the same red/green/blue order. After the third component of entry 3 the pointer returns to 0.
- R6: While the pointer is 4 or more, accesses to select 3 are ignored. The pointer, the sub-index and the overlay table are left as they were, and a read returns 0.
- R7: Select 2 reaches control byte (pointer − 4) only while the pointer is 4 to 7. Byte 0 is the read mask, 1 the blink mask, 2 the command byte and 3 the test byte. Outside that window writes are dropped and reads return 0. Select 2 never moves the pointer.
- R8: In the command byte (pointer 6), bit 0 enables overlay plane 0 and bit 1 enables overlay plane 1, driven on ovl_en[0] and ovl_en[1]. Bits 5:4 set the blink on/off periods: code 0 gives 16/48, 1 gives 16/16, 2 gives 32/32 and 3 gives 64/64 frames.
- R9: The lookup port returns {red[23:16], green[15:8], blue[7:0]} one cycle after the index. Index bit 8 clear selects main entry idx[7:0]; bit 8 set selects overlay entry idx[1:0].
- R10: Loading the pointer partway through a triple discards the partial components, so the next component written is red.
- R11: When read and write strobes arrive together, the write is performed and the read is dropped, so the read data output keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 0 pointer, 1 main color, 2 control, 3 overlay color |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| lk_idx | input | 9 | Lookup index; bit 8 picks the overlay table |
| lk_color | output | 24 | Registered 24-bit color for lk_idx |
| ovl_en | output | 2 | Overlay plane enables from the command byte |
| blink_on_frames | output | 7 | Blink on period in frames |
| blink_off_frames | output | 7 | Blink off period in frames |

## Verification
A sub-index that drifts shows up in the lookup of the next committed entry, with its components rotated or merged. It also shows as the pointer advancing one access too early or too late, which a read of select 0 exposes at once. A wrong range check on the pointer shows as a moved pointer, or as overlay or control contents changing after an access that should be ignored. Lookups and read-backs reveal this on the cycle after the access. Every main entry is streamed in and then both looked up and read back, so the commit order, the wrap and the byte ordering are all checked at the ports.

// File: rtl/cpal_pkg.sv
package cpal_pkg;

  localparam int COMP_W  = 8;
  localparam int COLOR_W = 3 * COMP_W;
  localparam int BLINK_W = 7;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_MAIN = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_OVL  = 2'd3
  } sel_e;

  // frames the overlay stays visible for a given blink code
  function automatic logic [BLINK_W-1:0] blink_on_len(input logic [1:0] code);
    case (code)
      2'd0:    return BLINK_W'(16);
      2'd1:    return BLINK_W'(16);
      2'd2:    return BLINK_W'(32);
      default: return BLINK_W'(64);
    endcase
  endfunction

  // frames the overlay stays hidden for a given blink code
  function automatic logic [BLINK_W-1:0] blink_off_len(input logic [1:0] code);
    case (code)
      2'd0:    return BLINK_W'(48);
      2'd1:    return BLINK_W'(16);
      2'd2:    return BLINK_W'(32);
      default: return BLINK_W'(64);
    endcase
  endfunction

  // component 0 is red in the top byte, 2 is blue in the bottom byte
  function automatic logic [COMP_W-1:0] pick_comp(input logic [COLOR_W-1:0] rgb,
                                                  input logic [1:0] idx);
    case (idx)
      2'd0:    return rgb[COLOR_W-1 -: COMP_W];
      2'd1:    return rgb[2*COMP_W-1 -: COMP_W];
      default: return rgb[COMP_W-1:0];
    endcase
  endfunction

endpackage

// File: rtl/cpal_seq.sv
module cpal_seq
  import cpal_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int OVL_N  = 4,
  parameter int CTRL_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       sel,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] ptr,
  output logic [1:0]       sub,
  output logic             in_ovl,
  output logic             in_ctrl,
  output logic             wr_step,
  output logic             rd_eff,
  output logic             commit_main,
  output logic             commit_ovl
);

  localparam logic [PTR_W-1:0] OVL_TOP = (PTR_W)'(OVL_N - 1);
  localparam logic [PTR_W-1:0] CTRL_LO = (PTR_W)'(OVL_N);
  localparam logic [PTR_W-1:0] CTRL_HI = (PTR_W)'(OVL_N + CTRL_N - 1);

  logic acc, step_main, step_ovl, last;

  assign rd_eff    = rd & ~wr;
  assign acc       = wr | rd_eff;
  assign in_ovl    = ptr <= OVL_TOP;
  assign in_ctrl   = (ptr >= CTRL_LO) && (ptr <= CTRL_HI);
  assign step_main = acc && (sel == SEL_MAIN);
  assign step_ovl  = acc && (sel == SEL_OVL) && in_ovl;
  assign last      = sub == 2'd2;
  assign wr_step   = wr && (step_main || step_ovl);
  assign commit_main = wr && step_main && last;
  assign commit_ovl  = wr && step_ovl && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      sub <= 2'd0;
    end else if (wr && sel == SEL_PTR) begin
      ptr <= wdata;
      sub <= 2'd0;
    end else if (step_main) begin
      if (last) begin
        ptr <= ptr + 1'b1;
        sub <= 2'd0;
      end else begin
        sub <= sub + 2'd1;
      end
    end else if (step_ovl) begin
      if (last) begin
        ptr <= (ptr == OVL_TOP) ? '0 : ptr + 1'b1;
        sub <= 2'd0;
      end else begin
        sub <= sub + 2'd1;
      end
    end
  end

  // R3: sub-index never reaches the unused fourth slot
  a_r3_sub_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sub != 2'd3);

  a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_PTR) |=> (ptr == $past(wdata)) && (sub == 2'd0));

  a_r3_main_advance: assert property (@(posedge clk) disable iff (!rst_n)
    commit_main |=> (ptr == (PTR_W)'($past(ptr) + 1'b1)) && (sub == 2'd0));

  a_r5_ovl_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ovl && ptr == OVL_TOP) |=> (ptr == '0));

  a_r6_ovl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr || rd) && sel == SEL_OVL && !in_ovl) |=> ($stable(ptr) && $stable(sub)));

  a_r7_ctrl_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr || rd) && sel == SEL_CTRL) |=> ($stable(ptr) && $stable(sub)));

endmodule

// File: rtl/cpal_ram.sv
module cpal_ram #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] paddr,
  output logic [DW-1:0] pdata,
  input  logic [AW-1:0] laddr,
  output logic [DW-1:0] ldata
);

  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // host side peek, registered by the caller
  assign pdata = mem[paddr];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ldata <= mem[laddr];
  end

endmodule

// File: rtl/cpal_ctrl.sv
module cpal_ctrl
  import cpal_pkg::*;
#(
  parameter int CTRL_N  = 4,
  parameter int CMD_IDX = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_req,
  input  logic                       in_range,
  input  logic [$clog2(CTRL_N)-1:0]  idx,
  input  logic [COMP_W-1:0]          wdata,
  output logic [COMP_W-1:0]          rd_data,
  output logic [1:0]                 ovl_en,
  output logic [BLINK_W-1:0]         blink_on,
  output logic [BLINK_W-1:0]         blink_off
);

  logic [CTRL_N-1:0][COMP_W-1:0] regs;
  logic [COMP_W-1:0] cmd;

  for (genvar g = 0; g < CTRL_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_req && in_range && idx == g)
        regs[g] <= wdata;
    end
  end

  assign rd_data   = in_range ? regs[idx] : '0;
  assign cmd       = regs[CMD_IDX];
  assign ovl_en    = cmd[1:0];
  assign blink_on  = blink_on_len(cmd[5:4]);
  assign blink_off = blink_off_len(cmd[5:4]);

  a_r7_ctrl_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !in_range) |=> $stable(regs));

  a_r8_blink_order: assert property (@(posedge clk) disable iff (!rst_n)
    blink_on <= blink_off);

endmodule

// File: rtl/cpal_regport.sv
module cpal_regport
  import cpal_pkg::*;
#(
  parameter int OVL_N   = 4,
  parameter int CTRL_N  = 4,
  parameter int CMD_IDX = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          host_sel,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [COMP_W-1:0]   host_wdata,
  output logic [COMP_W-1:0]   host_rdata,
  input  logic [COMP_W:0]     lk_idx,
  output logic [COLOR_W-1:0]  lk_color,
  output logic [1:0]          ovl_en,
  output logic [BLINK_W-1:0]  blink_on_frames,
  output logic [BLINK_W-1:0]  blink_off_frames
);

  localparam int PTR_W   = COMP_W;
  localparam int OVL_AW  = $clog2(OVL_N);
  localparam int CTRL_AW = $clog2(CTRL_N);
  localparam logic [PTR_W-1:0] CTRL_LO = (PTR_W)'(OVL_N);

  logic [PTR_W-1:0]   ptr;
  logic [1:0]         sub;
  logic               in_ovl, in_ctrl, wr_step, rd_eff, commit_main, commit_ovl;
  logic [COMP_W-1:0]  stage_r, stage_g, ctrl_rd, rdata_q;
  logic [COLOR_W-1:0] triple, main_peek, ovl_peek, main_lk, ovl_lk;
  logic [CTRL_AW-1:0] ctrl_idx;
  logic               lk_ovl_q;

  cpal_seq #(.PTR_W(PTR_W), .OVL_N(OVL_N), .CTRL_N(CTRL_N)) seq_i (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .rd(host_rd), .sel(host_sel),
    .wdata(host_wdata), .ptr(ptr), .sub(sub), .in_ovl(in_ovl), .in_ctrl(in_ctrl),
    .wr_step(wr_step), .rd_eff(rd_eff), .commit_main(commit_main),
    .commit_ovl(commit_ovl)
  );

  // partial components wait here until blue arrives
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_r <= '0;
      stage_g <= '0;
    end else if (wr_step) begin
      if (sub == 2'd0) stage_r <= host_wdata;
      if (sub == 2'd1) stage_g <= host_wdata;
    end
  end

  assign triple = {stage_r, stage_g, host_wdata};

  cpal_ram #(.AW(PTR_W), .DW(COLOR_W)) main_ram_i (
    .clk(clk), .we(commit_main), .waddr(ptr), .wdata(triple),
    .paddr(ptr), .pdata(main_peek), .laddr(lk_idx[PTR_W-1:0]), .ldata(main_lk)
  );

  cpal_ram #(.AW(OVL_AW), .DW(COLOR_W)) ovl_ram_i (
    .clk(clk), .we(commit_ovl), .waddr(ptr[OVL_AW-1:0]), .wdata(triple),
    .paddr(ptr[OVL_AW-1:0]), .pdata(ovl_peek), .laddr(lk_idx[OVL_AW-1:0]),
    .ldata(ovl_lk)
  );

  assign ctrl_idx = CTRL_AW'(ptr - CTRL_LO);

  cpal_ctrl #(.CTRL_N(CTRL_N), .CMD_IDX(CMD_IDX)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .wr_req(host_wr && host_sel == SEL_CTRL), .in_range(in_ctrl),
    .idx(ctrl_idx), .wdata(host_wdata), .rd_data(ctrl_rd),
    .ovl_en(ovl_en), .blink_on(blink_on_frames), .blink_off(blink_off_frames)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (host_rd && rd_eff) begin
      case (host_sel)
        SEL_PTR:  rdata_q <= ptr;
        SEL_MAIN: rdata_q <= pick_comp(main_peek, sub);
        SEL_CTRL: rdata_q <= ctrl_rd;
        default:  rdata_q <= in_ovl ? pick_comp(ovl_peek, sub) : '0;
      endcase
    end
  end

  assign host_rdata = rdata_q;

  always_ff @(posedge clk) lk_ovl_q <= lk_idx[PTR_W];

  assign lk_color = lk_ovl_q ? ovl_lk : main_lk;

  a_r11_rd_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_rd) |=> $stable(host_rdata));

  a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

endmodule

// File: tb/cpal_regport_tb.sv
module cpal_regport_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic [8:0]  lk_idx = 9'd0;
  logic [23:0] lk_color;
  logic [1:0]  ovl_en;
  logic [6:0]  blink_on_frames, blink_off_frames;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cpal_regport dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .lk_idx(lk_idx), .lk_color(lk_color), .ovl_en(ovl_en),
    .blink_on_frames(blink_on_frames), .blink_off_frames(blink_off_frames)
  );

  function automatic int pat(int i, int c);
    if (c == 0) return (i ^ 8'h5A) & 255;
    if (c == 1) return (i * 3) & 255;
    return (~i) & 255;
  endfunction

  function automatic int opat(int i, int c);
    return (8'hC0 + i * 16 + c) & 255;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwr(int sel, int d);
    host_sel = 2'(sel); host_wdata = 8'(d); host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(int sel, output int d);
    host_sel = 2'(sel); host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic look(int idx, output int c);
    lk_idx = 9'(idx);
    @(negedge clk);
    c = lk_color;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rdata", host_rdata, 0);
    chk("R1 ovl_en", ovl_en, 0);
    chk("R1 blink on", blink_on_frames, 16);
    chk("R1 blink off", blink_off_frames, 48);
    hrd(0, v); chk("R1 ptr", v, 0);
    for (int p = 4; p < 8; p++) begin
      hwr(0, p); hrd(2, v); chk("R1 ctrl byte", v, 0);
    end

    // R2: pointer load and readback
    hwr(0, 8'h9C); hrd(0, v); chk("R2 ptr readback", v, 8'h9C);

    // R3: stream all main entries from 0, wrapping back to 0
    hwr(0, 0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) hwr(1, pat(i, c));
    hrd(0, v); chk("R3 ptr wrap", v, 0);

    // R9: look up every main entry
    for (int i = 0; i < 256; i++) begin
      look(i, v);
      chk("R9 main lookup", v, (pat(i, 0) << 16) | (pat(i, 1) << 8) | pat(i, 2));
    end

    // R4: read back every component in order, then across the wrap
    hwr(0, 0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        hrd(1, v); chk("R4 main read", v, pat(i, c));
      end
    hrd(0, v); chk("R4 ptr wrap", v, 0);
    hwr(0, 255);
    for (int c = 0; c < 3; c++) begin hrd(1, v); chk("R4 read 255", v, pat(255, c)); end
    hrd(1, v); chk("R4 read after wrap", v, pat(0, 0));

    // R10: reload mid-triple discards partial components
    hwr(0, 10); hwr(1, 8'h11); hwr(1, 8'h22);
    hwr(0, 10); hwr(1, 8'hAA); hwr(1, 8'hBB); hwr(1, 8'hCC);
    look(10, v); chk("R10 entry", v, 24'hAABBCC);
    hrd(0, v); chk("R10 ptr", v, 11);

    // R5: overlay entries
    hwr(0, 0);
    for (int i = 0; i < 4; i++)
      for (int c = 0; c < 3; c++) hwr(3, opat(i, c));
    hrd(0, v); chk("R5 ovl wrap", v, 0);
    for (int i = 0; i < 4; i++) begin
      look(256 + i, v);
      chk("R5 ovl lookup", v, (opat(i, 0) << 16) | (opat(i, 1) << 8) | opat(i, 2));
    end
    for (int i = 0; i < 4; i++)
      for (int c = 0; c < 3; c++) begin
        hrd(3, v); chk("R5 ovl read", v, opat(i, c));
      end
    hrd(0, v); chk("R5 ovl read wrap", v, 0);

    // R6: overlay access out of range is ignored
    hwr(0, 5); hwr(3, 8'hEE);
    hrd(0, v); chk("R6 ptr kept", v, 5);
    hrd(3, v); chk("R6 read zero", v, 0);
    hrd(0, v); chk("R6 ptr kept after read", v, 5);
    for (int i = 0; i < 4; i++) begin
      look(256 + i, v);
      chk("R6 ovl unchanged", v, (opat(i, 0) << 16) | (opat(i, 1) << 8) | opat(i, 2));
    end
    hwr(0, 5); hwr(1, 8'h01); hwr(3, 8'hEE); hwr(1, 8'h02); hwr(1, 8'h03);
    look(5, v); chk("R6 sub kept", v, 24'h010203);
    hrd(0, v); chk("R6 ptr after triple", v, 6);

    // R7: control window 4..7, no pointer movement
    for (int p = 4; p < 8; p++) begin
      hwr(0, p); hwr(2, 8'h80 + p);
      hrd(0, v); chk("R7 ptr stays", v, p);
    end
    hwr(0, 8); hwr(2, 8'hFF); hrd(2, v); chk("R7 read outside", v, 0);
    hwr(0, 3); hwr(2, 8'hFF); hrd(2, v); chk("R7 read below", v, 0);
    for (int p = 4; p < 8; p++) begin
      hwr(0, p); hrd(2, v); chk("R7 ctrl readback", v, 8'h80 + p);
    end

    // R8: command byte decode sweep
    hwr(0, 6);
    for (int code = 0; code < 4; code++)
      for (int en = 0; en < 4; en++) begin
        hwr(2, (code << 4) | en);
        chk("R8 ovl_en", ovl_en, en);
        chk("R8 blink on", blink_on_frames, (code == 0) ? 16 : (8 << code));
        chk("R8 blink off", blink_off_frames, (code == 0) ? 48 : (8 << code));
      end

    // R11: read and write together, write wins
    hwr(0, 20); hrd(0, v); chk("R11 setup", v, 20);
    host_sel = 2'd1; host_wdata = 8'h77; host_wr = 1'b1; host_rd = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    chk("R11 rdata held", host_rdata, 20);
    hwr(1, 8'h78); hwr(1, 8'h79);
    look(20, v); chk("R11 write done", v, 24'h777879);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule